// File: doc/BRIEF.md
# ADC Conversion-Ready Status Tracker

This block keeps the "new data" bookkeeping for a housekeeping ADC controller that converts five channels: one battery channel, two auxiliary channels and two temperature channels. For each channel it takes a one-cycle strobe when a conversion finishes and another when the host has finished reading that channel's result. It holds a sticky flag per channel, an aggregate available flag, and a 16-bit status word that the host reads. It also drives an active-low data-available pin.

The pin's behaviour comes from a two-bit mode field, which is the only writable part of the status word. Only encoding 01 gives a working data-available pin. The other three encodings are reserved, and the pin stays high under them. The reset value 10 is one of the reserved encodings, so software must program 01 before it uses the pin.

Three side inputs shape what is reported:
- The power-down input is reported directly in the status word.
- The scan flag decides how long the pin stays low.
- The buffer flag masks every data flag and releases the pin, because the flags carry no meaning when results go through a FIFO.

Top module: `adc_ready_tracker`

## Requirements
- R1: After synchronous reset, the status word reads 16'h8000 (mode field 2'b10, every other bit 0) and `dav_n_o` is high.
- R2: A conversion strobe on channel c sets that channel's flag, visible in the status word one clock later. Channel 0 (battery) is bit 6, channel 1 (aux A) is bit 4, channel 2 (aux B) is bit 3, channel 3 (temperature A) is bit 2, and channel 4 (temperature B) is bit 1.
- R3: A channel flag clears one clock after that channel's readout strobe. With neither strobe present, it holds its value.
- R4: When a conversion strobe and a readout strobe reach the same channel in the same cycle, the flag ends up set.
- R5: Bit 13 equals `pwrdn_i` in the same cycle: 1 means powered down, 0 means active.
- R6: Bit 11, the aggregate flag, sets one clock after any conversion strobe. It clears only in the cycle after the last pending channel flag has cleared.
- R7: A write loads `wr_data_i[15:14]` into the mode field one clock later. All other written bits are ignored.
- R8: With the mode field at 2'b01, `dav_n_o` goes low one clock after a conversion strobe. With the mode field at 00, 10 or 11, `dav_n_o` stays high.
- R9: With `scan_mode_i` high, once `dav_n_o` is low it stays low until every channel flag has been cleared.
- R10: With `scan_mode_i` low, any readout strobe releases `dav_n_o` one clock later, unless a conversion strobe arrives in the same cycle. The aggregate flag still follows R6.
- R11: While `buf_mode_i` is high, bits 11, 6, 4, 3, 2 and 1 read 0 and `dav_n_o` is high. Internal flags keep tracking and reappear once the buffer flag drops.
- R12: Bits 12, 10:7, 5 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done_i | input | 5 | Per-channel conversion-complete strobes (0 battery, 1–2 aux, 3–4 temperature) |
| read_done_i | input | 5 | Per-channel readout-complete strobes, same channel order |
| pwrdn_i | input | 1 | ADC power-down status |
| scan_mode_i | input | 1 | Scan mode flag |
| buf_mode_i | input | 1 | Buffer (FIFO) mode flag |
| wr_en_i | input | 1 | Status word write strobe |
| wr_data_i | input | 16 | Status word write data (only bits 15:14 used) |
| rd_data_o | output | 16 | Status word read data |
| dav_n_o | output | 1 | Active-low data-available pin |

## Verification
The embedded assertions check the per-cycle relations on every clock:
- a conversion strobe sets its flag, and a set beats a simultaneous readout;
- a readout clears the flag, and a flag holds with neither strobe present;
- a conversion raises the aggregate flag, and a write lands in the mode field;
- the pin is high under a reserved mode or in buffer mode, and the reserved bits stay zero.

Some behaviours only the bench's scenarios can show, because they compare against a reference model over multi-cycle sequences:
- the aggregate flag survives partial readouts;
- the pin is held until the last flag clears in scan mode, and released early outside it;
- flags re-emerge after buffer mode ends;
- writes that toggle every non-mode bit leave the rest of the word unchanged.

// File: rtl/adc_rdy_pkg.sv
package adc_rdy_pkg;

    localparam int NCH      = 5;
    localparam int REG_W    = 16;
    localparam int MODE_LSB = 14;
    localparam int PWR_BIT  = 13;
    localparam int AGG_BIT  = 11;

    typedef enum logic [1:0] {
        PM_RSV_A = 2'b00,
        PM_DAV   = 2'b01,
        PM_RSV_B = 2'b10,
        PM_RSV_C = 2'b11
    } pin_mode_e;

    localparam pin_mode_e PM_RESET = PM_RSV_B;

    typedef struct packed {
        pin_mode_e        mode;
        logic             pwrdn;
        logic             agg;
        logic [NCH-1:0]   flags;
    } status_t;

    // Bit position of each channel's flag in the status word.
    function automatic int chan_bit(input int ch);
        case (ch)
            0:       return 6;
            1:       return 4;
            2:       return 3;
            3:       return 2;
            default: return 1;
        endcase
    endfunction

    // Mask of bits that always read zero.
    function automatic logic [REG_W-1:0] rsvd_mask();
        logic [REG_W-1:0] m;
        m = '1;
        m[MODE_LSB+1:MODE_LSB] = 2'b00;
        m[PWR_BIT] = 1'b0;
        m[AGG_BIT] = 1'b0;
        for (int c = 0; c < NCH; c++) m[chan_bit(c)] = 1'b0;
        return m;
    endfunction

    function automatic logic [REG_W-1:0] pack_word(input status_t s);
        logic [REG_W-1:0] w;
        w = '0;
        w[MODE_LSB+1:MODE_LSB] = s.mode;
        w[PWR_BIT] = s.pwrdn;
        w[AGG_BIT] = s.agg;
        for (int c = 0; c < NCH; c++) w[chan_bit(c)] = s.flags[c];
        return w;
    endfunction

endpackage

// File: rtl/adc_chan_flags.sv
module adc_chan_flags
    import adc_rdy_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] conv_i,
    input  logic [N-1:0] read_i,
    output logic [N-1:0] flag_q,
    output logic [N-1:0] flag_nxt
);

    for (genvar g = 0; g < N; g++) begin : g_ch
        // Set has priority over a simultaneous readout.
        assign flag_nxt[g] = conv_i[g] | (flag_q[g] & ~read_i[g]);

        always_ff @(posedge clk) begin
            if (rst) flag_q[g] <= 1'b0;
            else     flag_q[g] <= flag_nxt[g];
        end

        assert_set_R2: assert property (@(posedge clk) disable iff (rst)
            conv_i[g] |=> flag_q[g]);

        // R4: set wins over a same-cycle readout
        assert_set_wins_R4: assert property (@(posedge clk) disable iff (rst)
            (conv_i[g] && read_i[g]) |=> flag_q[g]);

        assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
            (!conv_i[g] && read_i[g]) |=> !flag_q[g]);

        assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (!conv_i[g] && !read_i[g]) |=> $stable(flag_q[g]));
    end

endmodule

// File: rtl/adc_dav_ctrl.sv
module adc_dav_ctrl
    import adc_rdy_pkg::*;
#(
    parameter int N = NCH
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] conv_i,
    input  logic [N-1:0] read_i,
    input  logic [N-1:0] flag_nxt_i,
    input  logic         scan_i,
    output logic         agg_q,
    output logic         hold_q
);

    logic any_conv, any_read, any_left;

    assign any_conv = |conv_i;
    assign any_read = |read_i;
    assign any_left = |flag_nxt_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            agg_q  <= 1'b0;
            hold_q <= 1'b0;
        end else begin
            agg_q  <= any_conv | (agg_q & any_left);
            if (any_conv)
                hold_q <= 1'b1;
            else if (scan_i)
                hold_q <= hold_q & any_left;
            else
                hold_q <= hold_q & ~any_read;
        end
    end

    assert_agg_set_R6: assert property (@(posedge clk) disable iff (rst)
        any_conv |=> agg_q);

    assert_scan_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (scan_i && hold_q && any_left) |=> hold_q);

    assert_noscan_rel_R10: assert property (@(posedge clk) disable iff (rst)
        (!scan_i && any_read && !any_conv) |=> !hold_q);

endmodule

// File: rtl/adc_mode_reg.sv
module adc_mode_reg
    import adc_rdy_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output pin_mode_e        mode_q
);

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data_i[MODE_LSB-1:0];

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= PM_RESET;
        else if (wr_en_i) mode_q <= pin_mode_e'(wr_data_i[MODE_LSB+1:MODE_LSB]);
    end

    assert_mode_wr_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> (mode_q == $past(wr_data_i[MODE_LSB+1:MODE_LSB])));

    assert_mode_keep_R7: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(mode_q));

endmodule

// File: rtl/adc_ready_tracker.sv
module adc_ready_tracker
    import adc_rdy_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NCH-1:0]   conv_done_i,
    input  logic [NCH-1:0]   read_done_i,
    input  logic             pwrdn_i,
    input  logic             scan_mode_i,
    input  logic             buf_mode_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             dav_n_o
);

    logic [NCH-1:0] flag_q, flag_nxt;
    logic           agg_q, hold_q;
    pin_mode_e      mode_q;
    status_t        view;

    adc_chan_flags #(.N(NCH)) flags_i (
        .clk(clk), .rst(rst),
        .conv_i(conv_done_i), .read_i(read_done_i),
        .flag_q(flag_q), .flag_nxt(flag_nxt)
    );

    adc_dav_ctrl #(.N(NCH)) dav_i (
        .clk(clk), .rst(rst),
        .conv_i(conv_done_i), .read_i(read_done_i),
        .flag_nxt_i(flag_nxt), .scan_i(scan_mode_i),
        .agg_q(agg_q), .hold_q(hold_q)
    );

    adc_mode_reg mode_i (
        .clk(clk), .rst(rst),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .mode_q(mode_q)
    );

    always_comb begin
        view.mode  = mode_q;
        view.pwrdn = pwrdn_i;
        view.agg   = agg_q  & ~buf_mode_i;
        view.flags = flag_q & {NCH{~buf_mode_i}};
    end

    assign rd_data_o = pack_word(view);
    assign dav_n_o   = ~((mode_q == PM_DAV) & ~buf_mode_i & hold_q);

    assert_rsvd_zero_R12: assert property (@(posedge clk) disable iff (rst)
        (rd_data_o & rsvd_mask()) == '0);

    assert_pin_rsvd_mode_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_data_o[MODE_LSB+1:MODE_LSB] != 2'b01) |-> dav_n_o);

    assert_buf_mask_R11: assert property (@(posedge clk) disable iff (rst)
        buf_mode_i |-> (dav_n_o && !rd_data_o[AGG_BIT]));

    assert_pwrdn_R5: assert property (@(posedge clk) disable iff (rst)
        rd_data_o[PWR_BIT] == pwrdn_i);

endmodule

// File: tb/adc_ready_tracker_tb.sv
module adc_ready_tracker_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  conv = '0, rdn = '0;
    logic        pwrdn = 0, scan = 0, bufm = 0, wr_en = 0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        dav_n;

    int n_vec = 0, n_bad = 0;
    string phase = "R1";

    always #2 clk = ~clk;

    adc_ready_tracker dut_i (
        .clk(clk), .rst(rst), .conv_done_i(conv), .read_done_i(rdn),
        .pwrdn_i(pwrdn), .scan_mode_i(scan), .buf_mode_i(bufm),
        .wr_en_i(wr_en), .wr_data_i(wr_data),
        .rd_data_o(rd_data), .dav_n_o(dav_n)
    );

    // ---------------- behavioural reference model ----------------
    int m_flag[5];
    int m_mode, m_agg, m_pin;
    int bitpos[5] = '{6, 4, 3, 2, 1};

    always @(posedge clk) begin
        int left;
        if (rst) begin
            foreach (m_flag[c]) m_flag[c] = 0;
            m_mode = 2; m_agg = 0; m_pin = 0;
        end else begin
            left = 0;
            foreach (m_flag[c]) begin
                if (conv[c])     m_flag[c] = 1;
                else if (rdn[c]) m_flag[c] = 0;
                left += m_flag[c];
            end
            if (conv != 0)      m_agg = 1;
            else if (left == 0) m_agg = 0;
            if (conv != 0)      m_pin = 1;
            else if (scan)      m_pin = (left != 0) ? m_pin : 0;
            else if (rdn != 0)  m_pin = 0;
            if (wr_en) m_mode = wr_data[15:14];
        end
    end

    function automatic logic [15:0] exp_word();
        logic [15:0] w = '0;
        w[15:14] = m_mode[1:0];
        w[13] = pwrdn;
        if (!bufm) begin
            w[11] = m_agg[0];
            foreach (m_flag[c]) w[bitpos[c]] = m_flag[c][0];
        end
        return w;
    endfunction

    function automatic logic exp_pin();
        return !(m_mode == 1 && !bufm && m_pin == 1);
    endfunction

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            n_vec++;
            if (rd_data !== exp_word() || dav_n !== exp_pin()) begin
                n_bad++;
                $display("FAIL %s model: word=%h pin=%b expected word=%h pin=%b",
                         phase, rd_data, dav_n, exp_word(), exp_pin());
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // drive at posedge+1, then settle one cycle and sample at negedge
    task automatic cyc(input logic [4:0] c, input logic [4:0] r);
        @(posedge clk); #1;
        conv = c; rdn = r;
        @(posedge clk); #1;
        conv = '0; rdn = '0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0; wr_data = '0;
        @(negedge clk);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        phase = "R1";
        chk("R1 reset word", rd_data, 16'h8000);
        chk("R1 reset pin", {15'd0, dav_n}, 16'd1);

        // R8: reserved mode 10 keeps pin high despite pending data
        phase = "R8";
        cyc(5'b00001, 5'b0);
        chk("R8 reserved mode pin", {15'd0, dav_n}, 16'd1);
        cyc(5'b0, 5'b00001);

        phase = "R7";
        wr(16'h7FFF);   // mode 01, all other bits written as 1
        chk("R7 R12 write ignores other bits", rd_data, 16'h4000);

        // R2 / R3 each channel
        for (int c = 0; c < 5; c++) begin
            logic [15:0] e;
            phase = "R2";
            cyc(5'(1 << c), 5'b0);
            e = 16'h4800; e[bitpos[c]] = 1'b1;
            chk("R2 channel flag position", rd_data, e);
            chk("R8 pin low in mode 01", {15'd0, dav_n}, 16'd0);
            phase = "R3";
            cyc(5'b0, 5'(1 << c));
            chk("R3 flag cleared", rd_data, 16'h4000);
        end

        phase = "R4";
        cyc(5'b00100, 5'b0);
        cyc(5'b00100, 5'b00100);
        chk("R4 set wins", rd_data, 16'h4808);
        cyc(5'b0, 5'b00100);

        phase = "R5";
        @(posedge clk); #1 pwrdn = 1;
        @(negedge clk);
        chk("R5 power-down bit", rd_data, 16'h6000);
        @(posedge clk); #1 pwrdn = 0;

        phase = "R9";
        scan = 1;
        cyc(5'b11111, 5'b0);
        for (int c = 0; c < 4; c++) begin
            cyc(5'b0, 5'(1 << c));
            chk("R9 scan pin held", {15'd0, dav_n}, 16'd0);
        end
        cyc(5'b0, 5'b10000);
        chk("R9 scan pin released", {15'd0, dav_n}, 16'd1);
        chk("R6 aggregate cleared", rd_data, 16'h4000);

        phase = "R10";
        scan = 0;
        cyc(5'b00011, 5'b0);
        cyc(5'b0, 5'b00001);
        chk("R10 pin released early", {15'd0, dav_n}, 16'd1);
        chk("R6 aggregate kept", rd_data, 16'h4810);
        cyc(5'b0, 5'b00010);

        phase = "R11";
        cyc(5'b01000, 5'b0);
        @(posedge clk); #1 bufm = 1;
        @(negedge clk);
        chk("R11 buffer masks flags", rd_data, 16'h4000);
        chk("R11 buffer pin high", {15'd0, dav_n}, 16'd1);
        @(posedge clk); #1 bufm = 0;
        @(negedge clk);
        chk("R11 flags reappear", rd_data, 16'h4804);
        cyc(5'b0, 5'b01000);

        phase = "R8";
        wr(16'hC000);
        cyc(5'b00001, 5'b0);
        chk("R8 mode 11 pin high", {15'd0, dav_n}, 16'd1);
        wr(16'h0000);
        chk("R8 mode 00 pin high", {15'd0, dav_n}, 16'd1);
        wr(16'h4000);
        chk("R8 mode 01 pin low", {15'd0, dav_n}, 16'd0);

        phase = "R12";
        for (int i = 0; i < 400; i++) begin
            @(posedge clk); #1;
            conv    = 5'($urandom_range(0, 31)) & {5{($urandom_range(0, 3) == 0)}};
            rdn     = 5'($urandom_range(0, 31));
            scan    = ($urandom_range(0, 1) == 1);
            bufm    = ($urandom_range(0, 7) == 0);
            pwrdn   = ($urandom_range(0, 5) == 0);
            wr_en   = ($urandom_range(0, 15) == 0);
            wr_data = 16'($urandom) | 16'h4000 & ~16'h8000;
        end
        @(posedge clk); #1;
        conv = '0; rdn = '0; wr_en = 0; bufm = 0;
        @(negedge clk);
        chk("R12 reserved bits zero", rd_data & 16'h17A1, 16'h0000);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule